// File: doc/BRIEF.md
# Iterative radix-2 Montgomery multiplier

This block forms the Montgomery product of two operands, S ≡ X·Y·2^(-W) (mod M), for a W-bit odd modulus M. It processes one bit of X per clock. In each step it picks one of four addends: zero, Y, M or the precomputed Y+M. It adds that addend to a running sum and halves the sum. The addend choice comes from the current X bit and from a reduction bit. The reduction bit is the low bit of the running sum XOR (X bit AND low bit of Y). Because of that choice, every sum is even before it is halved.

The handshake is by level. The caller places X, Y and M on the inputs and raises `start`. The block samples the operands at the first rising edge that sees `start` high, and the operation begins there. It then runs W iterations and raises `ready`. `ready` and the result stay fixed for as long as `start` stays high. Pulling `start` low returns the controller to idle straight away, without waiting for a clock edge, whatever state it is in. This is also how a running operation is aborted. The result is not fully reduced: it lies in [0, 2M). A final subtraction and any domain conversion belong to the caller.

Top module: `mont_iter_mul`

## Requirements
- R1: After `rst_n` has been sampled low, `ready` is 0 and `result` is 0 while `start` stays low.
- R2: For odd M with 3 ≤ M < 2^(W-1) and X, Y < M, the final `result` satisfies result mod M = X·Y·2^(-W) mod M and result < 2M.
- R3: Call the rising edge that first sees `start` high while idle the accept edge. `ready` is 0 after that edge and after the next W-1 edges. It becomes 1 after the W-th edge that follows the accept edge.
- R4: While `start` stays high after `ready` has risen, `ready` stays 1 and `result` does not change.
- R5: Whenever `start` is low, `ready` is 0. Dropping `start` clears `ready` at once, with no clock edge needed.
- R6: Dropping `start` in the middle of an operation abandons it. A later start produces the correct result for the new operands.
- R7: X, Y and M are sampled at the accept edge. Changing `x_in`, `y_in` or `m_in` after that edge does not change the result of the running operation.
- R8: With X = 0 the result is exactly 0, for any Y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Level request. Low forces idle asynchronously |
| x_in | input | W | Multiplier operand X, consumed LSB first |
| y_in | input | W | Multiplicand operand Y |
| m_in | input | W | Odd modulus M, below 2^(W-1) |
| result | output | W | Montgomery product, in [0, 2M) |
| ready | output | 1 | High once the product is valid, while start stays high |

## Verification
Two events can fall on the same edge: the last accumulator step and the move to the done state. Both happen on the edge where the iteration counter reaches W-1. A fault there would show as one step too many or too few, or as `ready` appearing a cycle early or late. Each operation samples `ready` just before that edge and just after it, and then checks the result against a bench model built on modular halving. That model does not use the four-addend method. The abort path and the operand-change path aim at the other collisions: `start` falling in the middle of iterations, and new input values arriving while the stored copies are in use.

// File: rtl/mont_pkg.sv
// Package: shared types for the Montgomery multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package mont_pkg;

    // Controller states of the iterative multiplier.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } mstate_t;

endpackage

// File: rtl/mont_ctrl.sv
// Module: mont_ctrl
// Three-state controller (idle, calculate, done) with an iteration counter.
// A low start clears the state asynchronously. The next-state logic never
// reads start: while start is low the flop is held in idle anyway, so idle
// always advances to calculate once the clear is released.
// Assumes: W >= 2.
module mont_ctrl
    import mont_pkg::*;
#(
    parameter int W = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    output mstate_t state_o,
    output logic    ready
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mstate_t        state, state_nx;
    logic [CW-1:0]  iter_cnt;

    // Next-state selection: leave calculate once the last iteration is reached.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: state_nx = ST_CALC;
            ST_CALC: state_nx = (iter_cnt == LAST) ? ST_DONE : ST_CALC;
            ST_DONE: state_nx = ST_DONE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register: asynchronous return to idle on a low start.
    always_ff @(posedge clk or negedge start) begin
        if (!start) begin
            state <= ST_IDLE;
        end else if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Iteration counter: counts calculate cycles, cleared elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_CALC) begin
            iter_cnt <= '0;
        end else begin
            iter_cnt <= iter_cnt + 1'b1;
        end
    end

    assign state_o = state;
    assign ready   = (state == ST_DONE);

endmodule

// File: rtl/mont_xshift.sv
// Module: mont_xshift
// Multiplier register. It loads X while idle and rotates right once per
// iteration, so bit 0 is the X bit consumed in the current iteration.
// Assumes: load and shift are never high together.
module mont_xshift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] x_in,
    output logic         xbit
);
    logic [W-1:0] xr;

    // Operand capture or right rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xr <= '0;
        end else if (load) begin
            xr <= x_in;
        end else if (shift) begin
            xr <= {xr[0], xr[W-1:1]};
        end
    end

    assign xbit = xr[0];

endmodule

// File: rtl/mont_datapath.sv
// Module: mont_datapath
// Operand store, four-way addend selection and the halving accumulator.
// While idle it captures Y, M and Y+M and clears the sum. Each step
// computes sum <- (sum + addend) / 2, with the addend picked by {xbit, q}.
// Assumes: M odd, M < 2^(W-1), Y < M. The sum then stays below 2M < 2^W,
// and every pre-shift total fits in W+1 bits.
module mont_datapath #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         xbit,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] m_in,
    output logic [W-1:0] result
);
    logic [W-1:0] y_q, m_q, ypm_q, acc;
    logic [W-1:0] addend;
    logic [W:0]   total;
    logic         q_bit;
    logic [1:0]   sel;

    // Reduction bit: makes the pre-shift total even.
    assign q_bit = (xbit & y_q[0]) ^ acc[0];
    assign sel   = {xbit, q_bit};

    // Addend choice: 00 zero, 01 M, 10 Y, 11 Y+M.
    always_comb begin
        case (sel)
            2'b00:   addend = '0;
            2'b01:   addend = m_q;
            2'b10:   addend = y_q;
            default: addend = ypm_q;
        endcase
    end

    assign total = {1'b0, acc} + {1'b0, addend};

    // Operand capture and accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q   <= '0;
            m_q   <= '0;
            ypm_q <= '0;
            acc   <= '0;
        end else if (load) begin
            y_q   <= y_in;
            m_q   <= m_in;
            ypm_q <= y_in + m_in;
            acc   <= '0;
        end else if (step) begin
            acc   <= W'(total >> 1);
        end
    end

    assign result = acc;

endmodule

// File: rtl/mont_iter_mul.sv
// Module: mont_iter_mul (top)
// Bit-serial radix-2 Montgomery multiplier: result = X*Y*2^-W mod M,
// left in [0, 2M). Uses a level start/ready handshake.
// Assumes: M odd, 3 <= M < 2^(W-1), X and Y below M.
module mont_iter_mul
    import mont_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] m_in,
    output logic [W-1:0] result,
    output logic         ready
);
    mstate_t state;
    logic    in_idle, in_calc, xbit;

    assign in_idle = (state == ST_IDLE);
    assign in_calc = (state == ST_CALC);

    mont_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .state_o (state),
        .ready   (ready)
    );

    mont_xshift #(.W(W)) u_xsh (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_idle),
        .shift (in_calc),
        .x_in  (x_in),
        .xbit  (xbit)
    );

    mont_datapath #(.W(W)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (in_idle),
        .step   (in_calc),
        .xbit   (xbit),
        .y_in   (y_in),
        .m_in   (m_in),
        .result (result)
    );

endmodule

// File: rtl/mont_iter_mul_chk.sv
// Module: mont_iter_mul_chk
// Property checker bound to mont_iter_mul. Uses its own cycle counter
// to check the start-to-ready latency.
module mont_iter_mul_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         ready,
    input logic [W-1:0] result
);
    localparam int CW = $clog2(W + 3);
    localparam logic [CW-1:0] LAT = CW'(W + 1);

    logic [CW-1:0] wait_cnt;

    // Counts edges that see start high with ready still low.
    always_ff @(posedge clk) begin
        if (!rst_n || !start) begin
            wait_cnt <= '0;
        end else if (!ready && wait_cnt != LAT) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // R3
    ready_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (wait_cnt == LAT));

    // R3
    no_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ready) |-> (wait_cnt <= CW'(W)));

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> $stable(result));

    // R5
    drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> !ready);

endmodule

bind mont_iter_mul mont_iter_mul_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .ready  (ready),
    .result (result)
);

// File: tb/test_mont_iter_mul.sv
`timescale 1ns/1ps
module test_mont_iter_mul;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] x_in = '0, y_in = '0, m_in = '0;
    logic [W-1:0] result;
    logic         ready;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    mont_iter_mul #(.W(W)) i_mont_iter_mul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_in(x_in), .y_in(y_in), .m_in(m_in),
        .result(result), .ready(ready)
    );

    always #2.5 clk = ~clk;

    // Reference: reduce X*Y, then halve W times modulo the odd M.
    function automatic longint mont_ref(longint a, longint b, longint m);
        longint r = (a * b) % m;
        for (int i = 0; i < W; i++) begin
            r = (r[0]) ? ((r + m) >> 1) : (r >> 1);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One complete operation; optional input disturbance after accept.
    task automatic run_op(input longint x, input longint y, input longint m,
                          input bit disturb, input bit exact_zero);
        longint exp, got;
        @(negedge clk);
        x_in = W'(x); y_in = W'(y); m_in = W'(m);
        start = 1'b1;
        @(posedge clk);                      // accept edge
        if (disturb) begin
            @(negedge clk);
            x_in = W'($urandom); y_in = W'($urandom); m_in = W'($urandom) | 1'b1;
        end
        repeat (W - 1) @(posedge clk);
        @(negedge clk);
        chk(ready == 1'b0, "R3 ready early", longint'(ready), 0);
        @(posedge clk);
        @(negedge clk);
        chk(ready == 1'b1, "R3 ready late", longint'(ready), 1);
        exp = mont_ref(x, y, m);
        got = longint'(result);
        if (exact_zero)
            chk(got == 0, "R8 zero product", got, 0);
        else
            chk((got % m) == exp && got < 2 * m, disturb ? "R7 sampled operands" : "R2 product",
                got % m, exp);
        repeat (3) @(negedge clk);
        chk(ready == 1'b1 && longint'(result) == got, "R4 hold", longint'(result), got);
        start = 1'b0;
        #1;
        chk(ready == 1'b0, "R5 async drop", longint'(ready), 0);
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        longint m, x, y;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        chk(ready == 1'b0, "R1 ready after reset", longint'(ready), 0);
        chk(result == '0, "R1 result after reset", longint'(result), 0);
        rst_n = 1'b1;

        // Directed corners.
        run_op(1, 1, 3, 1'b0, 1'b0);
        run_op(32766, 32766, 32767, 1'b0, 1'b0);
        run_op(0, 12345, 32767, 1'b0, 1'b1);            // R8
        run_op(0, 1, 3, 1'b0, 1'b1);                    // R8
        run_op(4660, 22136, 30001, 1'b1, 1'b0);         // R7

        // R6: abort mid-run, then a fresh operation.
        @(negedge clk);
        x_in = 16'd999; y_in = 16'd777; m_in = 16'd1001; start = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(ready == 1'b0, "R6 abort clears ready", longint'(ready), 0);
        repeat (2) @(negedge clk);
        chk(ready == 1'b0, "R6 idle after abort", longint'(ready), 0);
        run_op(123, 456, 1001, 1'b0, 1'b0);             // R6 restart correct

        // Constrained random operands.
        for (int k = 0; k < 40; k++) begin
            m = longint'(($urandom & 32'h7FFF) | 32'h1);
            if (m < 3) m = 3;
            x = longint'($urandom) % m;
            y = longint'($urandom) % m;
            run_op(x, y, m, (k % 8) == 7, 1'b0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule